// File: doc/BRIEF.md
# Programmable Byte-Serial CRC Engine

This block runs a cyclic redundancy check over a stream of bytes, one byte per clock. The generator polynomial, the starting register value, an 8-bit mask applied to each incoming byte, the bit order within each byte, a 32-bit mask applied to the final remainder and an optional full reversal of that remainder are all supplied as inputs. The polynomial sits left-aligned in a 32-bit word without its leading term. A 16-bit or 8-bit code therefore runs on the same hardware, and its answer appears in the upper bits.

A one-cycle start pulse loads the starting value and drops any partial state. Bytes then enter on a valid/ready handshake. A one-cycle finish pulse copies the shift register to two outputs. The first is the raw register contents, which a transfer engine would write to memory. The second is the remainder after masking and optional reversal. A one-cycle done flag marks the update.

Top module: `crc_engine`

## Requirements
- R1: A cycle with `start_i` high loads the shift register from `init_i`. A byte offered in that cycle is not taken, and any earlier partial state is lost.
- R2: A byte is taken only when `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is low in any cycle where `start_i` or `finish_i` is high, and high otherwise. In cycles where no byte is taken and no start occurs, the shift register holds its value.
- R3: Each taken byte advances the register by eight bit steps. In each step the register shifts left by one and is XORed with `poly_i` when the bit leaving at position 31, XORed with the current data bit, equals 1. `poly_i` omits the leading term and is left-aligned. CRC-32 uses 0x04C11DB7.
- R4: Before the shifting, each byte is XORed with `data_xor_i`. If `data_lsb_first_i` is 0, the masked byte is consumed bit 7 first. If it is 1, the masked byte is consumed bit 0 first.
- R5: A cycle with `finish_i` high and `start_i` low sets `raw_o` to the register contents in the cycle after, with no remainder mask or reversal applied. `done_o` is high for exactly that one following cycle.
- R6: On the same update, `result_o` equals the register XORed with `rem_xor_i`. When `rem_rev_i` is 1, this value is then reversed across all 32 bits. With start value 0xFFFFFFFF, LSB-first data, remainder mask 0xFFFFFFFF and reversal on, the ASCII bytes "123456789" give 0xCBF43926.
- R7: When no finish is accepted, `raw_o` and `result_o` keep their values and `done_o` is low.
- R8: A finish right after a start, with no bytes taken in between, returns `init_i` on `raw_o`. `result_o` receives the normal post-processing of that value.
- R9: A 16-bit code runs left-aligned. With polynomial 0x10210000, start value 0xFFFF0000, no masks and no reversal, "123456789" gives 0x29B10000 on both outputs.
- R10: During reset, `done_o` is low and `raw_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load the start value; has priority over everything else |
| finish_i | input | 1 | Capture the raw and processed remainder |
| init_i | input | 32 | Start value for the shift register |
| poly_i | input | 32 | Left-aligned polynomial without its leading term |
| data_xor_i | input | 8 | Mask XORed into each byte |
| data_lsb_first_i | input | 1 | 1: consume each byte bit 0 first |
| rem_xor_i | input | 32 | Mask XORed into the remainder |
| rem_rev_i | input | 1 | 1: reverse all 32 remainder bits after masking |
| byte_valid_i | input | 1 | Byte offered |
| byte_ready_o | output | 1 | Byte can be taken this cycle |
| byte_i | input | 8 | Data byte |
| done_o | output | 1 | One-cycle flag: outputs updated |
| raw_o | output | 32 | Unprocessed register contents |
| result_o | output | 32 | Masked and optionally reversed remainder |

## Verification
A wrong value in the shift register does not show at the ports straight away. It stays hidden until the next finish, and is then visible on both `raw_o` and `result_o` one cycle after that pulse. The bench therefore ends short sequences with a finish often, including right after a start, so that any corrupted step, bit order or mask shows up within a few cycles. Output-side faults in the mask or reversal show on `result_o` alone, on the same cycle as `done_o`. They are compared against the value `raw_o` implies.

// File: rtl/crc_pkg.sv
package crc_pkg;
   localparam int unsigned CRC_W  = 32;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;
endpackage

// File: rtl/crc_byte_in.sv
module crc_byte_in #(
   parameter int unsigned BW = crc_pkg::BYTE_W
) (
   input  logic [BW-1:0]        byte_i,
   input  logic [BW-1:0]        mask_i,
   input  crc_pkg::bit_order_e  order_i,
   output logic [BW-1:0]        bits_o
);
   logic [BW-1:0] masked;
   logic [BW-1:0] flipped;

   assign masked = byte_i ^ mask_i;

   for (genvar i = 0; i < BW; i++) begin : g_flip
      assign flipped[i] = masked[BW-1-i];
   end

   assign bits_o = (order_i == crc_pkg::ORDER_LSB_FIRST) ? flipped : masked;
endmodule

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
   parameter int unsigned W  = crc_pkg::CRC_W,
   parameter int unsigned BW = crc_pkg::BYTE_W
) (
   input  logic [W-1:0]  state_i,
   input  logic [W-1:0]  poly_i,
   input  logic [BW-1:0] bits_i,
   output logic [W-1:0]  state_o
);
   logic [W-1:0] chain [BW+1];

   assign chain[0] = state_i;

   for (genvar k = 0; k < BW; k++) begin : g_bit
      logic fb;
      assign fb = chain[k][W-1] ^ bits_i[BW-1-k];
      assign chain[k+1] = {chain[k][W-2:0], 1'b0} ^ (poly_i & {W{fb}});
   end

   assign state_o = chain[BW];
endmodule

// File: rtl/crc_post.sv
module crc_post #(
   parameter int unsigned W = crc_pkg::CRC_W
) (
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] mask_i,
   input  logic         rev_i,
   output logic [W-1:0] result_o
);
   logic [W-1:0] masked;
   logic [W-1:0] flipped;

   assign masked = raw_i ^ mask_i;

   for (genvar i = 0; i < W; i++) begin : g_flip
      assign flipped[i] = masked[W-1-i];
   end

   assign result_o = rev_i ? flipped : masked;
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
   parameter int unsigned W  = crc_pkg::CRC_W,
   parameter int unsigned BW = crc_pkg::BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          finish_i,
   input  logic [W-1:0]  init_i,
   input  logic [W-1:0]  poly_i,
   input  logic [BW-1:0] data_xor_i,
   input  logic          data_lsb_first_i,
   input  logic [W-1:0]  rem_xor_i,
   input  logic          rem_rev_i,
   input  logic          byte_valid_i,
   output logic          byte_ready_o,
   input  logic [BW-1:0] byte_i,
   output logic          done_o,
   output logic [W-1:0]  raw_o,
   output logic [W-1:0]  result_o
);
   if (W < BW) begin : g_bad_width
      $error("crc_engine: W must be at least BW");
   end
   if (BW < 1) begin : g_bad_byte
      $error("crc_engine: BW must be positive");
   end

   logic [W-1:0]  lfsr_q;
   logic [W-1:0]  lfsr_next;
   logic [BW-1:0] feed_bits;
   logic [W-1:0]  post_val;
   logic          take;
   logic          capture;

   assign byte_ready_o = ~(start_i | finish_i);
   assign take         = byte_valid_i & byte_ready_o;
   assign capture      = finish_i & ~start_i;

   crc_byte_in #(.BW(BW)) u_byte_in (
      .byte_i  (byte_i),
      .mask_i  (data_xor_i),
      .order_i (crc_pkg::bit_order_e'(data_lsb_first_i)),
      .bits_o  (feed_bits)
   );

   crc_lfsr_step #(.W(W), .BW(BW)) u_step (
      .state_i (lfsr_q),
      .poly_i  (poly_i),
      .bits_i  (feed_bits),
      .state_o (lfsr_next)
   );

   crc_post #(.W(W)) u_post (
      .raw_i    (lfsr_q),
      .mask_i   (rem_xor_i),
      .rev_i    (rem_rev_i),
      .result_o (post_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q   <= '0;
         raw_o    <= '0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= capture;
         if (start_i) begin
            lfsr_q <= init_i;
         end else if (take) begin
            lfsr_q <= lfsr_next;
         end
         if (capture) begin
            raw_o    <= lfsr_q;
            result_o <= post_val;
         end
      end
   end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
   parameter int unsigned W  = 32,
   parameter int unsigned BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          finish_i,
   input logic [W-1:0]  init_i,
   input logic [W-1:0]  rem_xor_i,
   input logic          rem_rev_i,
   input logic          byte_valid_i,
   input logic          byte_ready_o,
   input logic          done_o,
   input logic [W-1:0]  raw_o,
   input logic [W-1:0]  result_o,
   input logic [W-1:0]  lfsr_q
);
   function automatic logic [W-1:0] flip_w(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   // R1: start loads init, whatever else is offered
   p_start_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> lfsr_q == $past(init_i));

   // R2: register holds when neither start nor a taken byte
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !(byte_valid_i && byte_ready_o)) |=> $stable(lfsr_q));

   // R5: done follows an accepted finish
   p_done_after_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (finish_i && !start_i) |=> done_o);

   // R5: raw output is the register before the finish edge
   p_raw_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (finish_i && !start_i) |=> raw_o == $past(lfsr_q));

   // R6: processed remainder relation
   p_post_relation_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (finish_i && !start_i) |=> result_o ==
         ($past(rem_rev_i) ? flip_w(raw_o ^ $past(rem_xor_i)) : (raw_o ^ $past(rem_xor_i))));

   // R7: outputs hold and done stays low without a finish
   p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(finish_i && !start_i) |=> (!done_o && $stable(raw_o) && $stable(result_o)));

   // R8: empty run returns the start value
   p_empty_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i ##1 (finish_i && !start_i)) |=> raw_o == $past(init_i, 2));
endmodule

bind crc_engine crc_engine_chk #(.W(W), .BW(BW)) i_crc_engine_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .finish_i     (finish_i),
   .init_i       (init_i),
   .rem_xor_i    (rem_xor_i),
   .rem_rev_i    (rem_rev_i),
   .byte_valid_i (byte_valid_i),
   .byte_ready_o (byte_ready_o),
   .done_o       (done_o),
   .raw_o        (raw_o),
   .result_o     (result_o),
   .lfsr_q       (lfsr_q)
);

// File: tb/test_crc_engine.sv
module test_crc_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, finish = 1'b0, valid = 1'b0;
   logic [31:0] init = '0, poly = '0, rxor = '0;
   logic [7:0]  dxor = '0, data = '0;
   logic        lsb_first = 1'b0, rrev = 1'b0;
   logic        ready, done;
   logic [31:0] raw, result;

   int compared = 0, mismatched = 0;
   bit finished = 1'b0;

   // behavioural model state
   int unsigned m_lfsr = 0, m_raw = 0, m_res = 0;
   bit          m_done = 0;

   always #10 clk = ~clk;

   crc_engine i_crc_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .finish_i(finish),
      .init_i(init), .poly_i(poly), .data_xor_i(dxor),
      .data_lsb_first_i(lsb_first), .rem_xor_i(rxor), .rem_rev_i(rrev),
      .byte_valid_i(valid), .byte_ready_o(ready), .byte_i(data),
      .done_o(done), .raw_o(raw), .result_o(result)
   );

   function automatic int unsigned mdl_byte(int unsigned st, int unsigned b);
      int unsigned v = (b ^ dxor) & 8'hFF;
      for (int i = 0; i < 8; i++) begin
         int bitpos = lsb_first ? i : 7 - i;
         int unsigned din = (v >> bitpos) & 1;
         int unsigned top = (st >> 31) & 1;
         st = st << 1;
         if ((top ^ din) == 1) st = st ^ poly;
      end
      return st;
   endfunction

   function automatic int unsigned mdl_post(int unsigned st);
      int unsigned v = st ^ rxor;
      int unsigned r = 0;
      if (!rrev) return v;
      for (int i = 0; i < 32; i++) if (((v >> i) & 1) == 1) r = r | (32'h1 << (31 - i));
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: inputs already driven; check ready, step model, check outputs
   task automatic tick();
      #1;
      chk("R2 ready", {31'b0, ready}, {31'b0, !(start || finish)});
      @(posedge clk);
      m_done = 0;
      if (!rst_n) begin
         m_lfsr = 0; m_raw = 0; m_res = 0;
      end else begin
         if (finish && !start) begin
            m_raw = m_lfsr; m_res = mdl_post(m_lfsr); m_done = 1;
         end
         if (start) m_lfsr = init;
         else if (valid && !finish) m_lfsr = mdl_byte(m_lfsr, data);
      end
      #1;
      chk("R5/R7 done", {31'b0, done}, {31'b0, m_done});
      chk("R5 raw", raw, m_raw);
      chk("R6 result", result, m_res);
   endtask

   task automatic go_start();
      start = 1; tick(); start = 0;
   endtask
   task automatic go_finish();
      finish = 1; tick(); finish = 0;
   endtask
   task automatic go_byte(logic [7:0] b);
      valid = 1; data = b; tick(); valid = 0;
   endtask
   task automatic go_string(string s);
      for (int i = 0; i < s.len(); i++) go_byte(s[i]);
   endtask

   initial begin
      @(posedge clk); #1;
      valid = 1; data = 8'h55; start = 1; finish = 1;
      tick(); tick();
      // R10: reset values
      chk("R10 done", {31'b0, done}, 32'h0);
      chk("R10 raw", raw, 32'h0);
      chk("R10 result", result, 32'h0);
      start = 0; finish = 0; valid = 0;
      rst_n = 1;
      tick();

      // R3 R4 R6: CRC-32 check value with a gap in the stream
      poly = 32'h04C11DB7; init = 32'hFFFFFFFF; lsb_first = 1;
      rxor = 32'hFFFFFFFF; rrev = 1; dxor = 8'h00;
      go_start();
      go_string("1234");
      tick(); tick();
      go_string("56789");
      go_finish();
      chk("R6 crc32 check value", result, 32'hCBF43926);

      // R9: left-aligned 16-bit code
      poly = 32'h10210000; init = 32'hFFFF0000; lsb_first = 0;
      rxor = 32'h0; rrev = 0;
      go_start();
      go_string("123456789");
      go_finish();
      chk("R9 ccitt raw", raw, 32'h29B10000);
      chk("R9 ccitt result", result, 32'h29B10000);

      // R8: empty run, post-processed
      init = 32'hA5A50F0F; rxor = 32'h0000FFFF; rrev = 1;
      go_start();
      go_finish();
      chk("R8 empty raw", raw, 32'hA5A50F0F);

      // R1: start mid-stream drops partial state; byte during start ignored
      poly = 32'h04C11DB7; init = 32'h12345678; rrev = 0; rxor = 0;
      go_start(); go_byte(8'h3C); go_byte(8'hC3);
      valid = 1; data = 8'hEE; go_start(); valid = 0;
      go_finish();
      chk("R1 restart", raw, 32'h12345678);

      // R2: finish with a byte offered does not consume it; back-to-back finish
      go_start(); go_byte(8'h01);
      valid = 1; data = 8'h77; finish = 1; tick(); tick(); finish = 0; valid = 0;
      go_finish();

      // R4: data mask and both orders, remainder mask without reversal
      for (int ord = 0; ord < 2; ord++) begin
         lsb_first = ord[0]; dxor = 8'hA3; rxor = 32'hDEADBEEF;
         go_start();
         for (int i = 0; i < 16; i++) go_byte(8'(i * 37 + 5));
         go_finish();
      end

      // R3 R6 R7: pseudo-random streams, idle cycles between
      for (int t = 0; t < 40; t++) begin
         poly = $urandom; init = $urandom; dxor = 8'($urandom);
         lsb_first = 1'($urandom); rxor = $urandom; rrev = 1'($urandom);
         go_start();
         for (int i = 0; i < 1 + t % 9; i++) begin
            valid = 1'($urandom); data = 8'($urandom); tick();
         end
         valid = 0;
         go_finish();
         tick(); tick();
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule